// File: doc/BRIEF.md
# Thread-partitioned reorder buffer

This block keeps program order for a core that runs two hardware threads at once. Micro-operations are allocated into it in program order, one thread per cycle and up to `ALLOC_W` entries at a time. Each entry then waits for a completion report, which may arrive in any order and may carry an exception flag. Entries leave through the commit port strictly in the order they were allocated within their own thread. The buffer tracks only order, completion and exceptions. Operand values, renaming and execution are handled elsewhere.

The total capacity is split into two equal, fixed partitions, 64 entries each with the default 128. Every partition is its own circular queue with its own head and tail. The entry index handed out at allocation carries the thread in its top bit and the slot within the partition in the lower bits. A completion report names that index. When both threads have a committable head, one entry retires per cycle and the choice alternates between the threads. A faulting head halts its own thread until that thread is flushed. A flush clears one partition and leaves the other one alone.

Top module: `rob_tp`

## Requirements
- R1: After reset, both partitions report empty and not full. No commit, exception or stall is signalled.
- R2: An accepted allocation of `alloc_num_i` entries for thread `alloc_tid_i` returns the indices in `alloc_idx_o`. Lane k carries `{alloc_tid_i, (tail + k) mod 64}`, so bit 6 is the thread and bits 5:0 are the slot. Lane k sits in bits `k*7 +: 7`.
- R3: Each thread owns exactly 64 entries. `full_o[t]` is high when 64 entries of thread t are live, and `empty_o[t]` is high when none are.
- R4: An allocation whose count exceeds the free entries of its own thread is refused. `alloc_ok_o` stays low, `stall_o` has only the bit of that thread set, and no state changes. This holds even when the other thread has free room.
- R5: Completions may arrive in any order. A completion that names a slot holding no live, uncompleted entry is ignored.
- R6: Commit is in allocation order per thread and retires at most one entry per cycle. Only the head of a thread may retire, and only once it has completed without an exception. `commit_idx_o` and `commit_tid_o` name the entry that retires at the coming clock edge.
- R7: When a thread's head completes with the exception flag, `exc_o` for that thread goes high the following cycle. That thread stops committing until it is flushed. The other thread keeps committing.
- R8: `flush_i[t]` empties partition t at the next edge, clears its exception and restarts its slot numbering at 0. The other partition keeps its contents and order.
- R9: When both heads are committable in the same cycle, the retiring thread alternates from one such cycle to the next.
- R10: Head and tail wrap from slot 63 back to slot 0 within a partition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request this cycle |
| alloc_tid_i | input | 1 | Thread of the allocation |
| alloc_num_i | input | 2 | Number of entries requested (0..ALLOC_W) |
| alloc_idx_o | output | 14 | Granted indices, 7 bits per lane |
| alloc_ok_o | output | 1 | Allocation accepted |
| stall_o | output | 2 | Per-thread refusal for lack of room |
| cmpl_valid_i | input | 1 | Completion report valid |
| cmpl_idx_i | input | 7 | Index of the completed entry |
| cmpl_exc_i | input | 1 | Completed entry raised an exception |
| commit_valid_o | output | 1 | An entry retires at the next edge |
| commit_tid_o | output | 1 | Thread of the retiring entry |
| commit_idx_o | output | 7 | Index of the retiring entry |
| exc_o | output | 2 | Per-thread faulting head waiting for flush |
| flush_i | input | 2 | Per-thread flush |
| full_o | output | 2 | Per-thread partition full |
| empty_o | output | 2 | Per-thread partition empty |

## Verification
A corrupted head pointer or slot state shows up at the commit port one cycle after the affected completion. The retiring index then differs from the next one in allocation order, or an entry retires that should still be waiting. A corrupted tail shows up at once on the next allocation, in `alloc_idx_o` and in `full_o`/`empty_o`. A leak between partitions is exposed by flushing or filling one thread while the other still holds entries, then draining the other thread and checking its order. An arbitration fault shows up within two contended cycles as a repeated thread on `commit_tid_o`.

// File: rtl/rob_tp_pkg.sv
`timescale 1ns/1ps
package rob_tp_pkg;
   localparam int THREADS = 2;

   // life cycle of one entry
   typedef enum logic [1:0] {
      SLOT_FREE  = 2'd0,
      SLOT_WAIT  = 2'd1,
      SLOT_DONE  = 2'd2,
      SLOT_FAULT = 2'd3
   } slot_state_e;
endpackage

// File: rtl/rob_part.sv
`timescale 1ns/1ps
// One thread's circular region: slot states plus head/tail with a wrap bit.
module rob_part #(
   parameter int DEPTH   = 64,
   parameter int ALLOC_W = 2,
   localparam int SLOT_W = $clog2(DEPTH),
   localparam int PTR_W  = SLOT_W + 1,
   localparam int NUM_W  = $clog2(ALLOC_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_en,
   input  logic [NUM_W-1:0]  alloc_num,
   input  logic              cmpl_en,
   input  logic [SLOT_W-1:0] cmpl_slot,
   input  logic              cmpl_exc,
   input  logic              pop,
   input  logic              flush,
   output logic [SLOT_W-1:0] tail_slot,
   output logic [PTR_W-1:0]  free_cnt,
   output logic [SLOT_W-1:0] head_slot,
   output logic              head_ready,
   output logic              head_fault,
   output logic              full,
   output logic              empty
);
   import rob_tp_pkg::*;

   if ((1 << SLOT_W) != DEPTH) begin : g_bad_depth
      $error("rob_part: DEPTH must be a power of two");
   end

   slot_state_e       st_q [DEPTH];
   logic [PTR_W-1:0]  head_q, tail_q;
   logic [PTR_W-1:0]  used;

   assign used       = tail_q - head_q;
   assign free_cnt   = PTR_W'(DEPTH) - used;
   assign full       = (used == PTR_W'(DEPTH));
   assign empty      = (used == '0);
   assign head_slot  = head_q[SLOT_W-1:0];
   assign tail_slot  = tail_q[SLOT_W-1:0];
   assign head_ready = (st_q[head_slot] == SLOT_DONE);
   assign head_fault = (st_q[head_slot] == SLOT_FAULT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      end else if (flush) begin
         head_q <= '0;
         tail_q <= '0;
         for (int i = 0; i < DEPTH; i++) st_q[i] <= SLOT_FREE;
      end else begin
         if (pop) begin
            st_q[head_slot] <= SLOT_FREE;
            head_q          <= head_q + PTR_W'(1);
         end
         // only a live, still-waiting entry may take a completion
         if (cmpl_en && st_q[cmpl_slot] == SLOT_WAIT)
            st_q[cmpl_slot] <= cmpl_exc ? SLOT_FAULT : SLOT_DONE;
         if (alloc_en) begin
            for (int k = 0; k < ALLOC_W; k++) begin
               if (NUM_W'(k) < alloc_num)
                  st_q[tail_slot + SLOT_W'(k)] <= SLOT_WAIT;
            end
            tail_q <= tail_q + PTR_W'(alloc_num);
         end
      end
   end
endmodule

// File: rtl/rob_arb.sv
`timescale 1ns/1ps
// Picks the thread that retires this cycle.
module rob_arb #(
   parameter bit FAIR = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] ready,
   output logic [1:0] grant
);
   if (FAIR) begin : g_alt
      logic favour_q;
      always_comb begin
         grant = ready;
         if (&ready) grant = favour_q ? 2'b10 : 2'b01;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      favour_q <= 1'b0;
         else if (&ready) favour_q <= ~favour_q;
      end
   end else begin : g_fixed
      assign grant = ready[0] ? 2'b01 : ready;
   end
endmodule

// File: rtl/rob_tp.sv
`timescale 1ns/1ps
module rob_tp #(
   parameter int DEPTH_TOTAL = 128,
   parameter int ALLOC_W     = 2,
   parameter bit FAIR_COMMIT = 1'b1,
   localparam int PART_DEPTH = DEPTH_TOTAL / 2,
   localparam int SLOT_W     = $clog2(PART_DEPTH),
   localparam int IDX_W      = SLOT_W + 1,
   localparam int PTR_W      = SLOT_W + 1,
   localparam int NUM_W      = $clog2(ALLOC_W + 1)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     alloc_valid_i,
   input  logic                     alloc_tid_i,
   input  logic [NUM_W-1:0]         alloc_num_i,
   output logic [ALLOC_W*IDX_W-1:0] alloc_idx_o,
   output logic                     alloc_ok_o,
   output logic [1:0]               stall_o,
   input  logic                     cmpl_valid_i,
   input  logic [IDX_W-1:0]         cmpl_idx_i,
   input  logic                     cmpl_exc_i,
   output logic                     commit_valid_o,
   output logic                     commit_tid_o,
   output logic [IDX_W-1:0]         commit_idx_o,
   output logic [1:0]               exc_o,
   input  logic [1:0]               flush_i,
   output logic [1:0]               full_o,
   output logic [1:0]               empty_o
);
   import rob_tp_pkg::*;

   if (THREADS != 2) begin : g_bad_thr
      $error("rob_tp: exactly two threads are supported");
   end
   if (DEPTH_TOTAL % 2 != 0 || (1 << SLOT_W) != PART_DEPTH) begin : g_bad_depth
      $error("rob_tp: DEPTH_TOTAL must be twice a power of two");
   end
   if (ALLOC_W < 1 || ALLOC_W > PART_DEPTH) begin : g_bad_alloc
      $error("rob_tp: ALLOC_W out of range");
   end

   logic [PTR_W-1:0]  free_s [THREADS];
   logic [SLOT_W-1:0] tail_s [THREADS];
   logic [SLOT_W-1:0] head_s [THREADS];
   logic [1:0]        rdy_s, fault_s, grant_s;
   logic              fits;

   assign fits = (alloc_num_i <= NUM_W'(ALLOC_W)) &&
                 (PTR_W'(alloc_num_i) <= free_s[alloc_tid_i]);
   assign alloc_ok_o = alloc_valid_i && fits && !flush_i[alloc_tid_i];

   for (genvar t = 0; t < THREADS; t++) begin : g_thr
      logic a_en, c_en;
      assign a_en = alloc_ok_o && (alloc_tid_i == 1'(t));
      assign c_en = cmpl_valid_i && (cmpl_idx_i[IDX_W-1] == 1'(t));
      assign stall_o[t] = alloc_valid_i && (alloc_tid_i == 1'(t)) && !fits;

      rob_part #(
         .DEPTH   (PART_DEPTH),
         .ALLOC_W (ALLOC_W)
      ) u_part (
         .clk        (clk),
         .rst_n      (rst_n),
         .alloc_en   (a_en),
         .alloc_num  (alloc_num_i),
         .cmpl_en    (c_en),
         .cmpl_slot  (cmpl_idx_i[SLOT_W-1:0]),
         .cmpl_exc   (cmpl_exc_i),
         .pop        (grant_s[t]),
         .flush      (flush_i[t]),
         .tail_slot  (tail_s[t]),
         .free_cnt   (free_s[t]),
         .head_slot  (head_s[t]),
         .head_ready (rdy_s[t]),
         .head_fault (fault_s[t]),
         .full       (full_o[t]),
         .empty      (empty_o[t])
      );
   end

   for (genvar k = 0; k < ALLOC_W; k++) begin : g_lane
      assign alloc_idx_o[k*IDX_W +: IDX_W] =
         {alloc_tid_i, tail_s[alloc_tid_i] + SLOT_W'(k)};
   end

   rob_arb #(
      .FAIR (FAIR_COMMIT)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .ready (rdy_s & ~flush_i),
      .grant (grant_s)
   );

   assign commit_valid_o = |grant_s;
   assign commit_tid_o   = grant_s[1];
   assign commit_idx_o   = {grant_s[1], head_s[grant_s[1]]};
   assign exc_o          = fault_s;
endmodule

// File: rtl/rob_tp_chk.sv
`timescale 1ns/1ps
module rob_tp_chk #(
   parameter int IDX_W = 7,
   parameter int NUM_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             alloc_valid_i,
   input logic             alloc_tid_i,
   input logic [NUM_W-1:0] alloc_num_i,
   input logic [1:0]       stall_o,
   input logic [1:0]       full_o,
   input logic [1:0]       empty_o,
   input logic [1:0]       flush_i,
   input logic             commit_valid_o,
   input logic             commit_tid_o,
   input logic [IDX_W-1:0] commit_idx_o,
   input logic [1:0]       exc_o
);
   localparam int SLOT_W = IDX_W - 1;

   // slot each thread should retire next, tracked from the ports only
   logic [SLOT_W-1:0] next_q [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_q[0] <= '0;
         next_q[1] <= '0;
      end else begin
         for (int t = 0; t < 2; t++) begin
            if (flush_i[t])
               next_q[t] <= '0;
            else if (commit_valid_o && commit_tid_o == 1'(t))
               next_q[t] <= next_q[t] + SLOT_W'(1);
         end
      end
   end

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid_i && alloc_num_i != '0 && full_o[alloc_tid_i]) |-> stall_o[alloc_tid_i]);

   assert_stall_scope_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_o != 2'b00) |-> (alloc_valid_i && stall_o == (2'b01 << alloc_tid_i)));

   assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid_o |-> (commit_idx_o[SLOT_W-1:0] == next_q[commit_tid_o]));

   assert_commit_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid_o |-> !empty_o[commit_tid_o]);

   assert_fault_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid_o |-> !exc_o[commit_tid_o]);

   assert_flush_empty0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i[0] |=> empty_o[0]);

   assert_flush_empty1_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i[1] |=> empty_o[1]);
endmodule

bind rob_tp rob_tp_chk #(
   .IDX_W (IDX_W),
   .NUM_W (NUM_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .alloc_valid_i  (alloc_valid_i),
   .alloc_tid_i    (alloc_tid_i),
   .alloc_num_i    (alloc_num_i),
   .stall_o        (stall_o),
   .full_o         (full_o),
   .empty_o        (empty_o),
   .flush_i        (flush_i),
   .commit_valid_o (commit_valid_o),
   .commit_tid_o   (commit_tid_o),
   .commit_idx_o   (commit_idx_o),
   .exc_o          (exc_o)
);

// File: tb/sim_rob_tp.sv
`timescale 1ns/1ps
module sim_rob_tp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alloc_valid_i = 1'b0;
   logic        alloc_tid_i = 1'b0;
   logic [1:0]  alloc_num_i = 2'd0;
   logic [13:0] alloc_idx_o;
   logic        alloc_ok_o;
   logic [1:0]  stall_o;
   logic        cmpl_valid_i = 1'b0;
   logic [6:0]  cmpl_idx_i = 7'd0;
   logic        cmpl_exc_i = 1'b0;
   logic        commit_valid_o;
   logic        commit_tid_o;
   logic [6:0]  commit_idx_o;
   logic [1:0]  exc_o;
   logic [1:0]  flush_i = 2'b00;
   logic [1:0]  full_o;
   logic [1:0]  empty_o;

   rob_tp u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid_i(alloc_valid_i), .alloc_tid_i(alloc_tid_i), .alloc_num_i(alloc_num_i),
      .alloc_idx_o(alloc_idx_o), .alloc_ok_o(alloc_ok_o), .stall_o(stall_o),
      .cmpl_valid_i(cmpl_valid_i), .cmpl_idx_i(cmpl_idx_i), .cmpl_exc_i(cmpl_exc_i),
      .commit_valid_o(commit_valid_o), .commit_tid_o(commit_tid_o), .commit_idx_o(commit_idx_o),
      .exc_o(exc_o), .flush_i(flush_i), .full_o(full_o), .empty_o(empty_o)
   );

   always #4 clk = ~clk;   // 125 MHz

   int         n_chk = 0;
   int         n_bad = 0;
   bit         finished = 1'b0;
   logic [6:0] exp_q0[$];
   logic [6:0] exp_q1[$];
   int         mtail[2];
   bit         fault_mark[128];
   int         tid_log[$];

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic push_exp(input int tid, input logic [6:0] e);
      if (tid == 0) exp_q0.push_back(e); else exp_q1.push_back(e);
   endtask

   // driver: allocation, expected indices go to the scoreboard
   task automatic do_alloc(input int tid, input int num, input bit exp_ok);
      @(negedge clk);
      alloc_valid_i = 1'b1;
      alloc_tid_i   = tid[0];
      alloc_num_i   = 2'(num);
      #3;
      check(exp_ok ? "R2 alloc accepted" : "R4 alloc refused", int'(alloc_ok_o), int'(exp_ok));
      check("R4 stall flags", int'(stall_o), exp_ok ? 0 : (1 << tid));
      if (exp_ok) begin
         for (int k = 0; k < num; k++) begin
            logic [6:0] e;
            e = {tid[0], 6'((mtail[tid] + k) % 64)};
            check("R2 R10 alloc index", int'(alloc_idx_o[k*7 +: 7]), int'(e));
            push_exp(tid, e);
         end
         mtail[tid] = (mtail[tid] + num) % 64;
      end
      @(negedge clk);
      alloc_valid_i = 1'b0;
      alloc_num_i   = 2'd0;
   endtask

   task automatic do_complete(input logic [6:0] idx, input bit exc);
      @(negedge clk);
      cmpl_valid_i = 1'b1;
      cmpl_idx_i   = idx;
      cmpl_exc_i   = exc;
      if (exc) fault_mark[idx] = 1'b1;
      @(negedge clk);
      cmpl_valid_i = 1'b0;
      cmpl_exc_i   = 1'b0;
   endtask

   task automatic do_flush(input int tid);
      @(negedge clk);
      flush_i[tid] = 1'b1;
      if (tid == 0) exp_q0.delete(); else exp_q1.delete();
      mtail[tid] = 0;
      for (int i = 0; i < 64; i++) fault_mark[tid*64 + i] = 1'b0;
      @(negedge clk);
      flush_i = 2'b00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: every retirement is compared against the scoreboard
   always begin
      @(negedge clk);
      #3;
      if (rst_n && commit_valid_o) begin
         logic [6:0] e;
         n_chk++;
         if (commit_tid_o == 1'b0 && exp_q0.size() == 0 ||
             commit_tid_o == 1'b1 && exp_q1.size() == 0) begin
            n_bad++;
            $display("FAIL R6 unexpected commit actual=%0d expected=none", commit_idx_o);
         end else begin
            e = (commit_tid_o == 1'b0) ? exp_q0.pop_front() : exp_q1.pop_front();
            if (commit_idx_o !== e) begin
               n_bad++;
               $display("FAIL R6 commit order actual=%0d expected=%0d", commit_idx_o, e);
            end
         end
         if (fault_mark[commit_idx_o]) begin
            n_chk++;
            n_bad++;
            $display("FAIL R7 faulting entry retired actual=%0d expected=held", commit_idx_o);
         end
         tid_log.push_back(int'(commit_tid_o));
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [6:0] a0[$];
      logic [6:0] a1[$];
      logic [6:0] fidx;
      mtail[0] = 0;
      mtail[1] = 0;
      repeat (3) @(negedge clk);
      #3;
      // R1 reset state
      check("R1 empty", int'(empty_o), 3);
      check("R1 full", int'(full_o), 0);
      check("R1 commit", int'(commit_valid_o), 0);
      check("R1 exc", int'(exc_o), 0);
      check("R1 stall", int'(stall_o), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 a completion naming a dead slot is ignored
      do_complete(7'd64, 1'b0);
      do_alloc(1, 1, 1'b1);
      for (int i = 0; i < 3; i++) begin
         idle(1);
         #3;
         check("R5 stale completion ignored", int'(commit_valid_o), 0);
      end

      // R2 R3 R5 R6 out-of-order completion, in-order commit
      do_alloc(0, 2, 1'b1);
      #3;
      check("R3 not empty", int'(empty_o[0]), 0);
      do_complete(7'd1, 1'b0);
      #3;
      check("R6 non-head waits", int'(commit_valid_o), 0);
      do_complete(7'd0, 1'b0);
      idle(4);
      #3;
      check("R3 empty after drain", int'(empty_o[0]), 1);
      check("R6 thread0 drained", exp_q0.size(), 0);
      do_complete(7'd64, 1'b0);
      idle(3);
      #3;
      check("R3 both empty", int'(empty_o), 3);

      // R7 faulting head holds its thread, other thread runs on
      do_alloc(0, 2, 1'b1);
      do_alloc(1, 1, 1'b1);
      fidx = exp_q1[0];
      do_complete(fidx, 1'b1);
      #3;
      check("R7 exception raised", int'(exc_o), 2);
      a0 = exp_q0;
      do_complete(a0[0], 1'b0);
      do_complete(a0[1], 1'b0);
      idle(4);
      #3;
      check("R7 exception held", int'(exc_o), 2);
      check("R7 faulting entry kept", int'(empty_o[1]), 0);
      check("R7 other thread drained", exp_q0.size(), 0);

      // R8 flush clears one thread only
      do_alloc(0, 1, 1'b1);
      do_flush(1);
      #3;
      check("R8 flushed thread empty", int'(empty_o[1]), 1);
      check("R8 exception cleared", int'(exc_o), 0);
      check("R8 other thread kept", int'(empty_o[0]), 0);
      do_alloc(1, 1, 1'b1);   // slot numbering restarts at 0
      a0 = exp_q0;
      a1 = exp_q1;
      check("R8 restart index", int'(a1[0]), 64);
      do_complete(a0[0], 1'b0);
      do_complete(a1[0], 1'b0);
      idle(4);
      #3;
      check("R8 both drained", int'(empty_o), 3);

      // R3 R4 R10 fill thread0 across the wrap point
      for (int i = 0; i < 31; i++) do_alloc(0, 2, 1'b1);
      do_alloc(0, 1, 1'b1);
      do_alloc(0, 2, 1'b0);        // one slot free, two asked
      #3;
      check("R3 not yet full", int'(full_o[0]), 0);
      do_alloc(0, 1, 1'b1);
      #3;
      check("R3 full", int'(full_o), 1);
      do_alloc(0, 1, 1'b0);
      #3;
      check("R4 refused leaves full", int'(full_o[0]), 1);
      do_alloc(1, 2, 1'b1);        // other partition still has room
      a0 = exp_q0;
      for (int i = 63; i >= 1; i--) do_complete(a0[i], 1'b0);
      #3;
      check("R6 head incomplete holds", int'(commit_valid_o), 0);
      do_complete(a0[0], 1'b0);
      idle(70);
      #3;
      check("R3 R10 drained after wrap", int'(empty_o[0]), 1);
      check("R6 all retired", exp_q0.size(), 0);
      a1 = exp_q1;
      do_complete(a1[0], 1'b0);
      do_complete(a1[1], 1'b0);
      idle(4);

      // R9 alternation under contention
      for (int i = 0; i < 3; i++) do_alloc(0, 2, 1'b1);
      for (int i = 0; i < 3; i++) do_alloc(1, 2, 1'b1);
      a0 = exp_q0;
      a1 = exp_q1;
      for (int i = 1; i < 6; i++) do_complete(a0[i], 1'b0);
      for (int i = 1; i < 6; i++) do_complete(a1[i], 1'b0);
      tid_log.delete();
      do_complete(a0[0], 1'b0);
      do_complete(a1[0], 1'b0);
      idle(20);
      #3;
      check("R9 commit count", tid_log.size(), 12);
      if (tid_log.size() == 12) begin
         check("R9 lone thread0 first", tid_log[0], 0);
         check("R9 lone thread0 second", tid_log[1], 0);
         for (int k = 2; k < 9; k++)
            check("R9 alternation", int'(tid_log[k] != tid_log[k+1]), 1);
      end
      check("R9 queues drained", exp_q0.size() + exp_q1.size(), 0);

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule